// File: doc/BRIEF.md
# Parallel Quad DAC Latch Controller

This block is the digital front end of a four-channel, 8-bit, double-buffered digital-to-analog converter fed from an 8-bit parallel bus. A host puts a code on the bus and a channel number on a 2-bit address. It then pulls an active-low write strobe to fill one of four staging registers. A separate active-low load strobe copies every staging register into the output code registers together, so all channels can change on the same cycle.

Both strobes act as transparent latch controls, not edge triggers. While a strobe is low, the registers behind it follow their source on every system clock. When the strobe rises, the registers keep the last value they sampled. With both strobes low, bus data flows through to the addressed channel's output code. A shutdown request clears a single output-enable flag and leaves every register untouched.

All pins are sampled once into the system clock domain. The outputs then update on the following clock. A pin value present at clock edge k is therefore visible at the outputs after edge k+1.

Top module: `quad_dac_latch_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, all four output codes become 0x00 and `out_en` becomes 1 after that edge. Codes stay at zero until a load strobe transfers data.
- R2: Address value 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel n is presented on `dac_codes[8n+7:8n]`, and at most one staging register is written per cycle.
- R3: While `wr_n` is low, the addressed staging register takes the bus value on every cycle. After `wr_n` rises, it holds the value sampled in the last low cycle.
- R4: While `wr_n` is high, no staging register changes, whatever the bus and address carry.
- R5: While `ld_n` is low, every output code follows its staging register. After `ld_n` rises, the codes hold the last value transferred.
- R6: With `wr_n` and `ld_n` both low, the addressed channel's output code equals the bus value.
- R7: While `ld_n` is high, the output codes do not change, however many writes occur.
- R8: A high `shdn_req` drives `out_en` low. The output codes and staging registers keep their contents through the shutdown, and `out_en` returns high when the request drops.
- R9: If the address changes while `wr_n` stays low, the writes move to the newly addressed register. The previously addressed register keeps the value it held on its last selected cycle.
- R10: Any pin value sampled at clock edge k reaches `dac_codes` and `out_en` after edge k+1, which is a latency of two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Parallel data bus, bit 7 most significant |
| bus_addr | input | 2 | Channel select for writes |
| wr_n | input | 1 | Active-low transparent write strobe |
| ld_n | input | 1 | Active-low transparent load strobe |
| shdn_req | input | 1 | Hardware shutdown request, active high |
| dac_codes | output | 32 | Four 8-bit output codes, channel A in bits 7:0 |
| out_en | output | 1 | Global output enable, low in shutdown |

## Verification
A corrupted staging register stays hidden until a load strobe. The first load after the error then shows the wrong code on that lane two clocks after `ld_n` is sampled low. A corrupted output register shows at once on `dac_codes`, and with `ld_n` held high it never heals. A wrong write decode shows up as a stray code on a neighbouring lane at the next load. A pipeline-depth error shifts every transfer and the shutdown flag by a whole cycle. The bench compares all lanes on every cycle, so such an error is reported on the first cycle it reaches a port.

// File: rtl/qdl_pkg.sv
// Package: shared strobe encoding and a one-hot channel decode helper.
// Assumes channel counts small enough to fit a 32-bit index.
package qdl_pkg;

    // Active-low strobe levels seen on the pins.
    typedef enum logic {
        STB_ACTIVE = 1'b0,
        STB_IDLE   = 1'b1
    } strobe_t;

    // One-hot decode of a channel index; out-of-range indices give zero.
    function automatic logic [31:0] chan_onehot(input int unsigned idx, input int unsigned nch);
        logic [31:0] v;
        v = '0;
        if (idx < nch) v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/qdl_pin_sampler.sv
// qdl_pin_sampler: registers every host pin once into the system clock
// domain. Assumes the pins are already synchronous to clk (or were
// synchronised upstream). Reset parks both strobes idle and shutdown off.
module qdl_pin_sampler
    import qdl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_data,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic              pin_wr_n,
    input  logic              pin_ld_n,
    input  logic              pin_shdn,
    output logic [DATA_W-1:0] smp_data,
    output logic [ADDR_W-1:0] smp_addr,
    output strobe_t           smp_wr,
    output strobe_t           smp_ld,
    output logic              smp_shdn
);

    // Capture all pins on each clock; reset to an idle, powered state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data <= '0;
            smp_addr <= '0;
            smp_wr   <= STB_IDLE;
            smp_ld   <= STB_IDLE;
            smp_shdn <= 1'b0;
        end else begin
            smp_data <= pin_data;
            smp_addr <= pin_addr;
            smp_wr   <= strobe_t'(pin_wr_n);
            smp_ld   <= strobe_t'(pin_ld_n);
            smp_shdn <= pin_shdn;
        end
    end

endmodule

// File: rtl/qdl_write_decode.sv
// qdl_write_decode: turns the sampled address and write strobe into one
// write-enable per channel. Pure combinational; at most one bit is set.
module qdl_write_decode
    import qdl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] smp_addr,
    input  strobe_t           smp_wr,
    output logic [NUM_CH-1:0] ch_wr_en
);

    logic [31:0] sel_vec;

    // Decode the address only while the write strobe is active.
    always_comb begin
        sel_vec = chan_onehot(int'(smp_addr), NUM_CH);
        if (smp_wr == STB_ACTIVE) ch_wr_en = sel_vec[NUM_CH-1:0];
        else                      ch_wr_en = '0;
    end

endmodule

// File: rtl/qdl_channel.sv
// qdl_channel: one staging register and one output register for a single
// channel. Transparency is modelled per clock: the staging register's
// next value feeds the output register, so with both enables set the bus
// reaches the output in the same update.
module qdl_channel #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] bus_d,
    output logic [DATA_W-1:0] code
);

    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] stage_nx;
    logic [DATA_W-1:0] out_q;

    // Next staging value: bus when written, otherwise hold.
    always_comb begin
        stage_nx = wr_en ? bus_d : stage_q;
    end

    // Staging register, zero at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_nx;
    end

    // Output register follows the staging path while loading.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= '0;
        else if (ld_en) out_q <= stage_nx;
    end

    assign code = out_q;

endmodule

// File: rtl/qdl_out_ctrl.sv
// qdl_out_ctrl: registers the global output enable from the sampled
// shutdown request so it lines up in time with the channel codes.
module qdl_out_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_shdn,
    output logic out_en
);

    // Enable is the inverse of the sampled request; enabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_en <= 1'b1;
        else        out_en <= ~smp_shdn;
    end

endmodule

// File: rtl/quad_dac_latch_ctrl.sv
// quad_dac_latch_ctrl: top of the parallel quad DAC latch controller.
// Samples the host pins, decodes writes, and instantiates one staging and
// output register pair per channel. Assumes synchronous pins; latency from
// pin to output is two clocks.
module quad_dac_latch_ctrl
    import qdl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        bus_data,
    input  logic [$clog2(NUM_CH)-1:0] bus_addr,
    input  logic                     wr_n,
    input  logic                     ld_n,
    input  logic                     shdn_req,
    output logic [NUM_CH*DATA_W-1:0] dac_codes,
    output logic                     out_en
);

    localparam int ADDR_W = $clog2(NUM_CH);

    logic [DATA_W-1:0] smp_data;
    logic [ADDR_W-1:0] smp_addr;
    strobe_t           smp_wr;
    strobe_t           smp_ld;
    logic              smp_shdn;
    logic [NUM_CH-1:0] ch_wr_en;
    logic              ld_active;

    qdl_pin_sampler #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_data (bus_data),
        .pin_addr (bus_addr),
        .pin_wr_n (wr_n),
        .pin_ld_n (ld_n),
        .pin_shdn (shdn_req),
        .smp_data (smp_data),
        .smp_addr (smp_addr),
        .smp_wr   (smp_wr),
        .smp_ld   (smp_ld),
        .smp_shdn (smp_shdn)
    );

    qdl_write_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .smp_addr (smp_addr),
        .smp_wr   (smp_wr),
        .ch_wr_en (ch_wr_en)
    );

    // Load is a broadcast to every channel.
    always_comb begin
        ld_active = (smp_ld == STB_ACTIVE);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        qdl_channel #(.DATA_W(DATA_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (ch_wr_en[ch]),
            .ld_en (ld_active),
            .bus_d (smp_data),
            .code  (dac_codes[ch*DATA_W +: DATA_W])
        );
    end

    qdl_out_ctrl u_outctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_shdn (smp_shdn),
        .out_en   (out_en)
    );

endmodule

// File: rtl/qdl_checker.sv
// qdl_checker: temporal properties of the latch controller, bound to the
// top. Two-clock pin-to-output latency is assumed throughout.
module qdl_checker #(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [DATA_W-1:0]         bus_data,
    input logic [$clog2(NUM_CH)-1:0] bus_addr,
    input logic                      wr_n,
    input logic                      ld_n,
    input logic                      shdn_req,
    input logic [NUM_CH*DATA_W-1:0]  dac_codes,
    input logic                      out_en,
    input logic [NUM_CH-1:0]         ch_wr_en
);

    function automatic logic [DATA_W-1:0] lane(input logic [NUM_CH*DATA_W-1:0] v, input int idx);
        return v[idx*DATA_W +: DATA_W];
    endfunction

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_codes == '0 && out_en));

    // R2
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr_en));

    // R6
    flow_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(wr_n, 2) && !$past(ld_n, 2)
         && int'($past(bus_addr, 2)) < NUM_CH)
        |-> lane(dac_codes, int'($past(bus_addr, 2))) == $past(bus_data, 2));

    // R7
    hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(ld_n, 2)) |-> $stable(dac_codes));

    // R8
    shutdown_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_en == !$past(shdn_req, 2)));

endmodule

bind quad_dac_latch_ctrl qdl_checker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_qdl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_data  (bus_data),
    .bus_addr  (bus_addr),
    .wr_n      (wr_n),
    .ld_n      (ld_n),
    .shdn_req  (shdn_req),
    .dac_codes (dac_codes),
    .out_en    (out_en),
    .ch_wr_en  (ch_wr_en)
);

// File: tb/quad_dac_latch_ctrl_bench.sv
module quad_dac_latch_ctrl_bench;

    localparam int DW = 8;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] bus_data = '0;
    logic [1:0]    bus_addr = '0;
    logic          wr_n = 1'b1;
    logic          ld_n = 1'b1;
    logic          shdn_req = 1'b0;
    logic [NC*DW-1:0] dac_codes;
    logic          out_en;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Requirement model state
    logic [DW-1:0] m_stage [NC];
    logic [DW-1:0] m_out [NC];
    logic          m_oe;
    logic [DW-1:0] ms_data;
    logic [1:0]    ms_addr;
    logic          ms_wr, ms_ld, ms_shdn;

    always #5 clk = ~clk;

    quad_dac_latch_ctrl #(.DATA_W(DW), .NUM_CH(NC)) u_quad_dac_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .wr_n(wr_n), .ld_n(ld_n), .shdn_req(shdn_req),
        .dac_codes(dac_codes), .out_en(out_en)
    );

    function automatic logic [DW-1:0] lane_of(input logic [NC*DW-1:0] v, input int ch);
        return v[ch*DW +: DW];
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin m_stage[i] = '0; m_out[i] = '0; end
        m_oe = 1'b1; ms_data = '0; ms_addr = '0; ms_wr = 1'b1; ms_ld = 1'b1; ms_shdn = 1'b0;
    endtask

    // Model update at a clock edge: state from previously sampled pins, then sample pins.
    task automatic model_edge();
        logic [DW-1:0] nx [NC];
        for (int i = 0; i < NC; i++) nx[i] = m_stage[i];
        if (!ms_wr) nx[ms_addr] = ms_data;
        for (int i = 0; i < NC; i++) begin
            if (!ms_ld) m_out[i] = nx[i];
            m_stage[i] = nx[i];
        end
        m_oe = !ms_shdn;
        ms_data = bus_data; ms_addr = bus_addr; ms_wr = wr_n; ms_ld = ld_n; ms_shdn = shdn_req;
    endtask

    // One clock: drive pins, let the edge pass, compare all outputs with the model.
    task automatic step(input logic [DW-1:0] d, input logic [1:0] a, input logic w, input logic l,
                        input logic s, input string tag);
        bus_data = d; bus_addr = a; wr_n = w; ld_n = l; shdn_req = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int i = 0; i < NC; i++) check(tag, $sformatf("lane %0d", i), 32'(lane_of(dac_codes, i)), 32'(m_out[i]));
        check(tag, "out_en", 32'(out_en), 32'(m_oe));
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(8'h00, 2'd0, 1'b1, 1'b1, shdn_req, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_51D7));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        for (int i = 0; i < NC; i++) check("R1", "reset lane", 32'(lane_of(dac_codes, i)), 32'h0);
        check("R1", "reset out_en", 32'(out_en), 32'h1);

        // R7: writes with load idle leave codes at zero
        step(8'h5A, 2'd0, 1'b0, 1'b1, 1'b0, "R7");
        step(8'h5A, 2'd0, 1'b0, 1'b1, 1'b0, "R7");
        idle(3, "R7");
        check("R7", "lane A held at zero", 32'(lane_of(dac_codes, 0)), 32'h0);

        // R5: one-cycle load transfers staging to output
        step(8'h00, 2'd0, 1'b1, 1'b0, 1'b0, "R5");
        idle(3, "R5");
        check("R5", "lane A after load", 32'(lane_of(dac_codes, 0)), 32'h5A);

        // R2: each address lands in its own lane
        step(8'hA1, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
        step(8'hB2, 2'd1, 1'b0, 1'b1, 1'b0, "R2");
        step(8'hC3, 2'd2, 1'b0, 1'b1, 1'b0, "R2");
        step(8'hD4, 2'd3, 1'b0, 1'b1, 1'b0, "R2");
        step(8'h00, 2'd0, 1'b1, 1'b0, 1'b0, "R2");
        idle(2, "R2");
        check("R2", "lane A", 32'(lane_of(dac_codes, 0)), 32'hA1);
        check("R2", "lane B", 32'(lane_of(dac_codes, 1)), 32'hB2);
        check("R2", "lane C", 32'(lane_of(dac_codes, 2)), 32'hC3);
        check("R2", "lane D", 32'(lane_of(dac_codes, 3)), 32'hD4);

        // R3: last sampled value before the strobe rises is kept
        step(8'h11, 2'd2, 1'b0, 1'b1, 1'b0, "R3");
        step(8'h22, 2'd2, 1'b0, 1'b1, 1'b0, "R3");
        step(8'h33, 2'd2, 1'b0, 1'b1, 1'b0, "R3");
        step(8'h44, 2'd2, 1'b1, 1'b1, 1'b0, "R3");
        step(8'h00, 2'd0, 1'b1, 1'b0, 1'b0, "R3");
        idle(2, "R3");
        check("R3", "lane C last value", 32'(lane_of(dac_codes, 2)), 32'h33);

        // R4: bus and address activity with write idle changes nothing
        for (int k = 0; k < 6; k++) step(8'(k * 37 + 5), 2'(k), 1'b1, 1'b1, 1'b0, "R4");
        step(8'hEE, 2'd1, 1'b1, 1'b0, 1'b0, "R4");
        idle(2, "R4");
        check("R4", "lane A", 32'(lane_of(dac_codes, 0)), 32'hA1);
        check("R4", "lane B", 32'(lane_of(dac_codes, 1)), 32'hB2);
        check("R4", "lane C", 32'(lane_of(dac_codes, 2)), 32'h33);
        check("R4", "lane D", 32'(lane_of(dac_codes, 3)), 32'hD4);

        // R6 / R10: both strobes low, bus tracked with two-clock latency
        step(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, "R10");
        check("R10", "lane D not yet updated", 32'(lane_of(dac_codes, 3)), 32'hD4);
        step(8'h82, 2'd3, 1'b0, 1'b0, 1'b0, "R10");
        check("R10", "lane D after two clocks", 32'(lane_of(dac_codes, 3)), 32'h81);
        step(8'h83, 2'd3, 1'b0, 1'b0, 1'b0, "R6");
        check("R6", "lane D tracks", 32'(lane_of(dac_codes, 3)), 32'h82);
        step(8'h84, 2'd3, 1'b1, 1'b1, 1'b0, "R6");
        check("R6", "lane D tracks", 32'(lane_of(dac_codes, 3)), 32'h83);
        idle(2, "R6");
        check("R6", "lane D held", 32'(lane_of(dac_codes, 3)), 32'h83);

        // R9: address moves during a write
        step(8'h10, 2'd1, 1'b0, 1'b1, 1'b0, "R9");
        step(8'h20, 2'd2, 1'b0, 1'b1, 1'b0, "R9");
        step(8'h30, 2'd2, 1'b0, 1'b1, 1'b0, "R9");
        step(8'h00, 2'd0, 1'b1, 1'b0, 1'b0, "R9");
        idle(2, "R9");
        check("R9", "old lane B", 32'(lane_of(dac_codes, 1)), 32'h10);
        check("R9", "new lane C", 32'(lane_of(dac_codes, 2)), 32'h30);

        // R8: shutdown clears enable, keeps contents, still accepts writes
        step(8'h00, 2'd0, 1'b1, 1'b1, 1'b1, "R8");
        step(8'h00, 2'd0, 1'b1, 1'b1, 1'b1, "R8");
        check("R8", "out_en in shutdown", 32'(out_en), 32'h0);
        check("R8", "lane B kept", 32'(lane_of(dac_codes, 1)), 32'h10);
        step(8'h77, 2'd0, 1'b0, 1'b1, 1'b1, "R8");
        step(8'h00, 2'd0, 1'b1, 1'b1, 1'b0, "R8");
        idle(2, "R8");
        check("R8", "out_en restored", 32'(out_en), 32'h1);
        check("R8", "lane A kept", 32'(lane_of(dac_codes, 0)), 32'hA1);
        step(8'h00, 2'd0, 1'b1, 1'b0, 1'b0, "R8");
        idle(2, "R8");
        check("R8", "staging kept across shutdown", 32'(lane_of(dac_codes, 0)), 32'h77);

        // R10: random mix checked every cycle against the model
        for (int k = 0; k < 4000; k++) begin
            step(8'($urandom), 2'($urandom), ($urandom % 2) == 0, ($urandom % 10) >= 3,
                 ($urandom % 10) == 0, "R10");
        end

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        model_reset();
        for (int i = 0; i < NC; i++) check("R1", "re-reset lane", 32'(lane_of(dac_codes, i)), 32'h0);
        check("R1", "re-reset out_en", 32'(out_en), 32'h1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule